// File: doc/BRIEF.md
# Zero-Turnaround Pipelined SRAM Model

A synthesizable behavioural model of a synchronous SRAM whose bus never needs an idle cycle when the access direction changes. Every request is captured on a rising clock edge. The array commits a request two enabled edges after its address is captured. A read's data therefore leaves the output register in the same bus slot where a write's data is sampled. This lets reads and writes alternate on every clock.

A request starts when the continue input is low. That cycle loads the address and the direction, and the three mixed-polarity chip selects decide whether the access is live. While the continue input is high, the request continues the last loaded access through a 2-bit burst counter. The counter steps in linear or interleaved order, chosen by a static mode input. The 36-bit word is split into four 9-bit lanes, and each lane has its own write enable. A clock-enable input, active low, freezes all pipeline state. An asynchronous output enable only gates the output. A small parameterised array stands in for the full-size core.

Top module: `zbl_sram`

## Requirements
- R1: A load cycle (cont_i=0) selects the device only when cs0_ni=0, cs1_i=1 and cs2_ni=0 on the same edge. Any other combination is a deselect: it writes nothing and produces no read output.
- R2: Read data for an address captured at enabled edge k is in the output register after enabled edge k+2, and rdrive_o is then 1 while oe_ni=0.
- R3: For a write whose address is captured at enabled edge k, wdata_i is sampled at enabled edge k+2. Its lane enables bwe_i are captured with the address. Only the lanes j with bwe_i[j]=1 (bits 9j+8:9j) change.
- R4: Reads and writes may alternate on consecutive enabled edges with no idle cycle. A read always returns the newest data for each lane, including a write to the same address that is still in the pipeline.
- R5: A cycle with cont_i=1 ignores the chip selects and continues the last loaded access in the loaded direction. If the last load was a deselect, the continuation is a deselect as well.
- R6: With burst_ilv_i=0, continuation n after the load (n=1,2,3,4 and so on) uses the low two address bits base+n mod 4. The upper bits stay those of the loaded address.
- R7: With burst_ilv_i=1, continuation n uses the low two address bits base XOR (n mod 4).
- R8: While cke_ni=1, no state changes: the array, the pipeline, rdata_o and rdrive_o all hold.
- R9: rdrive_o is 1 only when oe_ni=0 and the last enabled edge completed a read, and rdata_o is 0 whenever rdrive_o is 0. oe_ni acts without a clock and never affects the pipeline.
- R10: After reset, rdrive_o=0 and rdata_o=0, and the pipeline holds no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_ni | input | 1 | Clock enable, active low; 1 stalls everything |
| cs0_ni | input | 1 | Chip select, active low |
| cs1_i | input | 1 | Chip select, active high |
| cs2_ni | input | 1 | Chip select, active low |
| cont_i | input | 1 | 1 continues the burst, 0 loads a new access |
| we_i | input | 1 | Direction on a load: 1 write, 0 read |
| bwe_i | input | 4 | Per-lane write enables, captured with the address |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 36 | Write data, sampled two enabled edges after its address |
| burst_ilv_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| rdata_o | output | 36 | Read data, 0 when not driven |
| rdrive_o | output | 1 | High while rdata_o carries read data |

## Verification
The assertions assume that reset is held low before the first clock edge. They also assume that burst_ilv_i and the chip selects are stable values, never X, on enabled edges. The stimulus drives every input at the falling edge and holds it through the next rising edge, and it changes burst_ilv_i only between bursts. Before any read, the stimulus writes every address once, so each expected value is known.

// File: rtl/zbl_pkg.sv
package zbl_pkg;
  localparam int DEF_LANES  = 4;
  localparam int DEF_LANE_W = 9;

  // low two address bits for burst step n
  function automatic logic [1:0] burst_low(input logic ilv, input logic [1:0] base,
                                           input logic [1:0] n);
    return ilv ? (base ^ n) : (base + n);
  endfunction
endpackage

// File: rtl/zbl_burst.sv
module zbl_burst
  import zbl_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              cont_i,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic              ilv_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              iss_vld_o,
  output logic              iss_wr_o,
  output logic [ADDR_W-1:0] iss_addr_o,
  output logic              act_o
);
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q, cnt_nx;
  logic              act_q, wr_q;

  assign cnt_nx = cnt_q + 2'd1;
  assign act_o  = act_q;

  always_comb begin
    if (cont_i) begin
      iss_vld_o  = act_q;
      iss_wr_o   = wr_q;
      iss_addr_o = {base_q[ADDR_W-1:2], burst_low(ilv_i, base_q[1:0], cnt_nx)};
    end else begin
      iss_vld_o  = sel_i;
      iss_wr_o   = wr_i;
      iss_addr_o = addr_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cnt_q  <= '0;
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
    end else if (en_i) begin
      if (cont_i) begin
        cnt_q <= cnt_nx;
      end else begin
        base_q <= addr_i;
        cnt_q  <= '0;
        act_q  <= sel_i;
        wr_q   <= wr_i;
      end
    end
  end
endmodule

// File: rtl/zbl_array.sv
module zbl_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DEPTH  = 1 << ADDR_W,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              wen_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [LANES-1:0]  wbe_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk_i) begin
      if (wen_i && wbe_i[g]) mem[waddr_i] <= wdata_i[g*LANE_W +: LANE_W];
    end
    assign rdata_o[g*LANE_W +: LANE_W] = mem[raddr_i];
  end
endmodule

// File: rtl/zbl_sram.sv
module zbl_sram
  import zbl_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = DEF_LANES,
  parameter int LANE_W = DEF_LANE_W,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cke_ni,
  input  logic              cs0_ni,
  input  logic              cs1_i,
  input  logic              cs2_ni,
  input  logic              cont_i,
  input  logic              we_i,
  input  logic [LANES-1:0]  bwe_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              burst_ilv_i,
  input  logic              oe_ni,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdrive_o
);
  typedef struct packed {
    logic              vld;
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [LANES-1:0]  be;
  } op_t;

  logic              en, sel, burst_act;
  logic              iss_vld, iss_wr;
  logic [ADDR_W-1:0] iss_addr;
  op_t               s1_q, s2_q;
  logic [DATA_W-1:0] arr_rd, fwd_rd, s2_data_q, dout_q;
  logic              rd_q, s2_wen;

  assign en  = !cke_ni;
  assign sel = !cs0_ni && cs1_i && !cs2_ni;

  zbl_burst #(.ADDR_W(ADDR_W)) u_burst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en),
    .cont_i     (cont_i),
    .sel_i      (sel),
    .wr_i       (we_i),
    .ilv_i      (burst_ilv_i),
    .addr_i     (addr_i),
    .iss_vld_o  (iss_vld),
    .iss_wr_o   (iss_wr),
    .iss_addr_o (iss_addr),
    .act_o      (burst_act)
  );

  // write commits from stage 2 with the data on the bus this edge
  assign s2_wen = en && s2_q.vld && s2_q.wr;

  zbl_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk_i   (clk_i),
    .wen_i   (s2_wen),
    .waddr_i (s2_q.addr),
    .wbe_i   (s2_q.be),
    .wdata_i (wdata_i),
    .raddr_i (s1_q.addr),
    .rdata_o (arr_rd)
  );

  // stage-1 read sees the array before the stage-2 write lands: bypass per lane
  for (genvar g = 0; g < LANES; g++) begin : g_fwd
    assign fwd_rd[g*LANE_W +: LANE_W] =
      (s2_q.vld && s2_q.wr && s2_q.be[g] && (s2_q.addr == s1_q.addr))
        ? wdata_i[g*LANE_W +: LANE_W] : arr_rd[g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q      <= '0;
      s2_q      <= '0;
      s2_data_q <= '0;
      dout_q    <= '0;
      rd_q      <= 1'b0;
    end else if (en) begin
      s1_q      <= '{vld: iss_vld, wr: iss_wr, addr: iss_addr, be: bwe_i};
      s2_q      <= s1_q;
      s2_data_q <= fwd_rd;
      rd_q      <= s2_q.vld && !s2_q.wr;
      if (s2_q.vld && !s2_q.wr) dout_q <= s2_data_q;
    end
  end

  assign rdrive_o = rd_q && !oe_ni;
  assign rdata_o  = rdrive_o ? dout_q : '0;
endmodule

// File: rtl/zbl_sram_chk.sv
module zbl_sram_chk #(
  parameter int DATA_W = 36
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cke_ni,
  input logic              cont_i,
  input logic              sel,
  input logic              burst_act,
  input logic              s1_vld,
  input logic              s1_wr,
  input logic              s2_vld,
  input logic              rd_q,
  input logic [DATA_W-1:0] dout_q
);
  assert_desel_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_ni && !cont_i && !sel) |=> !s1_vld);

  assert_read_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_ni && s1_vld && !s1_wr) ##1 !cke_ni |=> rd_q);

  assert_cont_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_ni && cont_i && !burst_act) |=> !s1_vld);

  assert_stall_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_ni |=> ($stable(dout_q) && $stable(rd_q) && $stable(s1_vld) && $stable(s2_vld)));
endmodule

bind zbl_sram zbl_sram_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cke_ni    (cke_ni),
  .cont_i    (cont_i),
  .sel       (sel),
  .burst_act (burst_act),
  .s1_vld    (s1_q.vld),
  .s1_wr     (s1_q.wr),
  .s2_vld    (s2_q.vld),
  .rd_q      (rd_q),
  .dout_q    (dout_q)
);

// File: tb/tb_zbl_sram.sv
`timescale 1ns/1ps
module tb_zbl_sram;
  logic        clk_i = 0, rst_ni = 0;
  logic        cke_ni = 0, cs0_ni = 1, cs1_i = 0, cs2_ni = 1, cont_i = 0, we_i = 0;
  logic [3:0]  bwe_i = 0;
  logic [5:0]  addr_i = 0;
  logic [35:0] wdata_i = 0;
  logic        burst_ilv_i = 0, oe_ni = 0;
  logic [35:0] rdata_o;
  logic        rdrive_o;

  zbl_sram dut (.*);

  always #5 clk_i = ~clk_i;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  string cur_req = "R10";

  // bench model
  logic [35:0] mem_m [64];
  logic        p1_vld = 0, p1_wr = 0, p2_vld = 0, p2_wr = 0;
  logic [5:0]  p1_addr = 0, p2_addr = 0;
  logic [3:0]  p1_be = 0, p2_be = 0;
  logic [35:0] p1_wd = 0, p2_wd = 0;
  logic [5:0]  b_base = 0;
  logic [1:0]  b_cnt = 0;
  logic        b_act = 0, b_wr = 0;

  typedef struct packed { logic rd; logic [35:0] d; } exp_t;
  exp_t exp_q[$];

  task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, updates model and pushes expected result
  task automatic drv(input bit stall, input logic [2:0] cs, input bit cont, input bit we,
                     input logic [5:0] a, input logic [3:0] be, input logic [35:0] wd);
    logic nv, nw;
    logic [5:0] na;
    logic [1:0] cn;
    @(negedge clk_i);
    cke_ni = stall; cs0_ni = cs[2]; cs1_i = cs[1]; cs2_ni = cs[0];
    cont_i = cont; we_i = we; addr_i = a; bwe_i = be;
    wdata_i = (p2_vld && p2_wr) ? p2_wd : 36'h0;
    @(posedge clk_i);
    #1;
    if (!stall) begin
      if (p2_vld && p2_wr)
        for (int j = 0; j < 4; j++) if (p2_be[j]) mem_m[p2_addr][j*9 +: 9] = p2_wd[j*9 +: 9];
      exp_q.push_back({(p2_vld && !p2_wr), (p2_vld && !p2_wr) ? mem_m[p2_addr] : 36'h0});
      if (cont) begin
        cn = b_cnt + 2'd1;
        nv = b_act; nw = b_wr;
        na = {b_base[5:2], burst_ilv_i ? (b_base[1:0] ^ cn) : (b_base[1:0] + cn)};
        b_cnt = cn;
      end else begin
        nv = (cs == 3'b010); nw = we; na = a;
        b_base = a; b_cnt = 0; b_act = nv; b_wr = we;
      end
      p2_vld = p1_vld; p2_wr = p1_wr; p2_addr = p1_addr; p2_be = p1_be; p2_wd = p1_wd;
      p1_vld = nv; p1_wr = nw; p1_addr = na; p1_be = be; p1_wd = wd;
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [3:0] be, input logic [35:0] d);
    drv(0, 3'b010, 0, 1, a, be, d);
  endtask
  task automatic rd(input logic [5:0] a);
    drv(0, 3'b010, 0, 0, a, 4'h0, 36'h0);
  endtask
  task automatic nop();
    drv(0, 3'b110, 0, 0, 6'h0, 4'h0, 36'h0);
  endtask
  task automatic cw(input logic [35:0] d);
    drv(0, 3'b010, 1, 0, 6'h0, 4'hf, d);
  endtask
  task automatic cr();
    drv(0, 3'b010, 1, 0, 6'h0, 4'h0, 36'h0);
  endtask
  task automatic stall();
    drv(1, 3'b110, 0, 0, 6'h0, 4'h0, 36'h0);
  endtask

  // monitor: compares each committed slot against the scoreboard
  always @(posedge clk_i) begin
    exp_t e;
    #3;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      if (e.rd && !oe_ni)
        chk(rdrive_o === 1'b1 && rdata_o === e.d, cur_req, rdata_o, e.d);
      else
        chk(rdrive_o === 1'b0 && rdata_o === 36'h0, cur_req, rdata_o, 36'h0);
    end
  end

  initial begin
    #500000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=%h exp=%h", 36'h0, 36'h1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [35:0] held;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    #1;
    chk(rdrive_o === 1'b0 && rdata_o === 36'h0, "R10 reset", rdata_o, 36'h0);

    // fill every address
    cur_req = "R3 fill";
    for (int a = 0; a < 64; a++) wr(6'(a), 4'hf, {6'(a), 30'h1234_5678 ^ 30'(a * 977)});
    nop(); nop();
    cur_req = "R2 read";
    rd(6'd3); rd(6'd17); rd(6'd63); nop(); nop();

    // partial lanes
    cur_req = "R3 lanes";
    wr(6'd5, 4'b0101, 36'hA_AAAA_AAAA); nop(); nop(); rd(6'd5); nop(); nop();

    // back-to-back alternation with in-flight forwarding
    cur_req = "R4 fwd";
    wr(6'd7, 4'b0101, 36'h1_1111_1111); rd(6'd7);
    wr(6'd7, 4'b1010, 36'h2_2222_2222); rd(6'd7); rd(6'd7);
    rd(6'd9); wr(6'd9, 4'b1111, 36'h3_3333_3333); rd(6'd9); wr(6'd10, 4'b0011, 36'h4_4444_4444); rd(6'd10);
    nop(); nop();

    // deselect patterns write nothing
    cur_req = "R1 desel";
    drv(0, 3'b000, 0, 1, 6'd20, 4'hf, 36'hF_FFFF_FFFF);
    drv(0, 3'b011, 0, 1, 6'd20, 4'hf, 36'hE_EEEE_EEEE);
    drv(0, 3'b110, 0, 1, 6'd20, 4'hf, 36'hD_DDDD_DDDD);
    drv(0, 3'b100, 0, 0, 6'd21, 4'h0, 36'h0);
    nop(); nop(); rd(6'd20); nop(); nop();

    // continuation after a deselect load is idle
    cur_req = "R5 cont-desel";
    nop(); cw(36'h5_5555_5555); cr(); nop(); nop(); rd(6'd0); nop(); nop();

    // linear burst from base low bits 2
    cur_req = "R6 linear";
    burst_ilv_i = 0;
    wr(6'd10, 4'hf, 36'h0_0000_0A10); cw(36'h0_0000_0A11); cw(36'h0_0000_0A12); cw(36'h0_0000_0A13);
    nop(); nop();
    rd(6'd10); cr(); cr(); cr(); cr(); nop(); nop();
    rd(6'd8); rd(6'd9); rd(6'd11); nop(); nop();

    // interleaved burst from base low bits 1, chip selects ignored on continue
    cur_req = "R7 interleaved";
    @(negedge clk_i); burst_ilv_i = 1;
    wr(6'd13, 4'hf, 36'h0_0000_0B00);
    drv(0, 3'b110, 1, 0, 6'h0, 4'hf, 36'h0_0000_0B01);
    cw(36'h0_0000_0B02); cw(36'h0_0000_0B03); nop(); nop();
    rd(6'd13); cr(); cr(); cr(); nop(); nop();
    rd(6'd12); rd(6'd14); rd(6'd15); nop(); nop();
    @(negedge clk_i); burst_ilv_i = 0;

    // stall with a write in flight, then hold of a visible read
    cur_req = "R8 stall";
    wr(6'd40, 4'hf, 36'h6_6666_6666); stall(); stall(); nop(); stall(); nop();
    rd(6'd40); nop(); nop();
    held = rdata_o;
    stall(); stall(); stall();
    #2;
    chk(rdrive_o === 1'b1 && rdata_o === held, "R8 hold", rdata_o, held);
    nop(); nop();

    // output enable gating
    cur_req = "R9 oe";
    @(negedge clk_i); oe_ni = 1;
    rd(6'd41); nop(); nop();
    stall();
    #1;
    chk(rdrive_o === 1'b0 && rdata_o === 36'h0, "R9 oe off", rdata_o, 36'h0);
    oe_ni = 0;
    #1;
    chk(rdrive_o === 1'b1 && rdata_o === mem_m[41], "R9 oe async on", rdata_o, mem_m[41]);
    nop(); nop(); nop();

    #20;
    chk(exp_q.size() == 0, "R2 drain", 36'(exp_q.size()), 36'h0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule